// File: doc/BRIEF.md
# Configuration Bitstream Header Inspector

This block sits beside a 32-bit configuration stream and watches its opening words as they go by. It identifies the image (its security type from a magic halfword and its section type from the halfword after that magic). It also picks up two header flags buried deep in the stream, one for encryption and one for compression. From those two flags and the selected configuration port width (16 or 32 bit), it derives the clock-to-data ratio code that the configuration port must be programmed with. It never alters, stores or delays the stream.

A run begins with a one-cycle start pulse, which also latches the port-width select. Words are counted from zero on every accepted beat after the start cycle. The stream interface is valid/ready. The block never applies back-pressure: `s_ready` is held high, so a beat is accepted in every cycle where `s_valid` is high. When word 229 has been seen, the results appear together with `done_o`. If the stream ends early, `done_o` and `error_o` rise together and no ratio is produced.

Top module: `cfg_hdr_inspector`

## Requirements
- R1: `s_ready` is always 1. Word indices count accepted beats from 0, starting with the first beat after the start cycle. Beats before the first start, in the start cycle itself, or after a run has finished have no effect on any output.
- R2: `encrypted_o` is 1 exactly when bits [3:2] of word 69 are nonzero.
- R3: `compressed_o` is 1 exactly when bit 1 of word 229 is 0.
- R4: With a 16-bit port (`width32_i`=0 at start), the ratio code (x1=0, x2=1, x4=2, x8=3) is 0 for a plain image, 1 for encrypted and uncompressed, and 2 for any compressed image.
- R5: With a 32-bit port (`width32_i`=1 at start), the ratio code is 0 for a plain image, 2 for encrypted and uncompressed, and 3 for any compressed image.
- R6: Halfwords are taken little-endian, so the low half of a word is bits [15:0]. `security_o` is decided as follows, checking word 0 first and word 1 second:
  - If the low half of word 0 equals MAGIC_PLAIN (16'hA5C3), `security_o` is 1 (unencrypted).
  - If the low half of word 0 equals MAGIC_CIPHER (16'h5A3C), `security_o` is 2 (encrypted).
  - Otherwise the same two checks are made on the low half of word 1.
  - If neither word matches, `security_o` is 0 (invalid).
- R7: `section_o` is read from the high half of the word that holds the magic: 1 for 16'h0F01 (peripheral), 2 for 16'h0F02 (core), 0 for any other value (unknown). When the security type is invalid, `section_o` is 0.
- R8: `done_o` rises exactly one cycle after the beat carrying word 229 and `error_o` stays 0. All results then stay unchanged until the next start.
- R9: If `s_last` arrives with a beat whose index is below 229, then one cycle later `done_o` and `error_o` are both 1 and every result field is 0. `s_last` on word 229 itself counts as success.
- R10: A start pulse clears `done_o`, `error_o` and all results in the next cycle, even in the cycle a completion is due. It also aborts any run in progress. Only the width latched at start affects the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new inspection, latch width |
| width32_i | input | 1 | Port width select: 1 = 32-bit, 0 = 16-bit |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream ready, always 1 |
| s_data | input | 32 | Stream word |
| s_last | input | 1 | Final word of the stream |
| encrypted_o | output | 1 | Encryption flag |
| compressed_o | output | 1 | Compression flag |
| section_o | output | 2 | 0 unknown, 1 peripheral, 2 core |
| security_o | output | 2 | 0 invalid, 1 unencrypted, 2 encrypted |
| ratio_o | output | 2 | Clock-to-data ratio code |
| done_o | output | 1 | Inspection finished |
| error_o | output | 1 | Stream ended before word 229 |

## Verification
Two pairs of events can land in the same cycle.

The first pair is end of stream and capture of the final flag word. Half of the sweep raises `s_last` on word 229 itself, and that run must finish as a success with the full ratio, not as an error.

The second pair is a start pulse and a completion. A start is driven in the very cycle in which a finished run would raise `done_o`, with a junk beat on the stream at the same time. The outputs must come back cleared, and the following stream must decode correctly. Any shift in word numbering caused by the junk beat would show up as an invalid security type.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  typedef enum logic [1:0] {
    SECT_NONE   = 2'd0,
    SECT_PERIPH = 2'd1,
    SECT_CORE   = 2'd2
  } sect_e;

  typedef enum logic [1:0] {
    SECU_INVALID = 2'd0,
    SECU_PLAIN   = 2'd1,
    SECU_CIPHER  = 2'd2
  } secu_e;

  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_RUN  = 2'd1,
    TRK_FIN  = 2'd2
  } trk_state_e;

  // Header flag bit positions inside their words
  localparam int ENC_FIELD_LSB = 2;
  localparam int CMP_FIELD_BIT = 1;

  // A 32-bit port doubles every non-unity ratio, i.e. one step up in code
  function automatic ratio_e pick_ratio(input logic enc, input logic cmp,
                                        input logic wide);
    ratio_e base;
    if (!enc && !cmp) return RATIO_X1;
    base = cmp ? RATIO_X4 : RATIO_X2;
    return wide ? ratio_e'(base + 2'd1) : base;
  endfunction

endpackage

// File: rtl/cfg_hdr_tracker.sv
module cfg_hdr_tracker
  import cfg_hdr_pkg::*;
#(
  parameter int LAST_IDX = 229,
  parameter int CNT_W    = $clog2(LAST_IDX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             beat_i,
  input  logic             last_i,
  output logic             take_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             fin_ok_o,
  output logic             fin_err_o
);

  trk_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == CNT_W'(LAST_IDX));
  assign take_o = (state_q == TRK_RUN) && beat_i && !start_i;
  assign idx_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= TRK_IDLE;
      cnt_q     <= '0;
      fin_ok_o  <= 1'b0;
      fin_err_o <= 1'b0;
    end else begin
      fin_ok_o  <= 1'b0;
      fin_err_o <= 1'b0;
      if (start_i) begin
        state_q <= TRK_RUN;
        cnt_q   <= '0;
      end else if (take_o) begin
        if (at_end) begin
          state_q  <= TRK_FIN;
          fin_ok_o <= 1'b1;
        end else if (last_i) begin
          state_q   <= TRK_FIN;
          fin_err_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx_o <= CNT_W'(LAST_IDX)); // R1

  AST_FIN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fin_ok_o && fin_err_o)); // R9

  AST_NO_COUNT_AFTER_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TRK_FIN && !start_i) |=> $stable(cnt_q)); // R1

endmodule

// File: rtl/cfg_hdr_image.sv
module cfg_hdr_image
  import cfg_hdr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int CNT_W   = $clog2(CMP_IDX + 1),
  parameter logic [DATA_W/2-1:0] MAGIC_PLAIN    = 16'hA5C3,
  parameter logic [DATA_W/2-1:0] MAGIC_CIPHER   = 16'h5A3C,
  parameter logic [DATA_W/2-1:0] SECT_ID_PERIPH = 16'h0F01,
  parameter logic [DATA_W/2-1:0] SECT_ID_CORE   = 16'h0F02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              enc_o,
  output logic              cmp_o,
  output sect_e             sect_o,
  output secu_e             secu_o
);

  localparam int HW = DATA_W / 2;

  logic [DATA_W-1:0] w0_q, w1_q;
  logic [HW-1:0]     lo0, hi0, lo1, hi1, sid;
  logic              hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w0_q  <= '0;
      w1_q  <= '0;
      enc_o <= 1'b0;
      cmp_o <= 1'b0;
    end else if (take_i) begin
      if (idx_i == CNT_W'(0)) w0_q <= data_i;
      if (idx_i == CNT_W'(1)) w1_q <= data_i;
      if (idx_i == CNT_W'(ENC_IDX))
        enc_o <= |data_i[ENC_FIELD_LSB +: 2];
      if (idx_i == CNT_W'(CMP_IDX))
        cmp_o <= ~data_i[CMP_FIELD_BIT];
    end
  end

  assign lo0 = w0_q[HW-1:0];
  assign hi0 = w0_q[DATA_W-1:HW];
  assign lo1 = w1_q[HW-1:0];
  assign hi1 = w1_q[DATA_W-1:HW];

  always_comb begin
    secu_o = SECU_INVALID;
    sid    = '0;
    hit    = 1'b0;
    if (lo0 == MAGIC_PLAIN) begin
      secu_o = SECU_PLAIN;  sid = hi0; hit = 1'b1;
    end else if (lo0 == MAGIC_CIPHER) begin
      secu_o = SECU_CIPHER; sid = hi0; hit = 1'b1;
    end else if (lo1 == MAGIC_PLAIN) begin
      secu_o = SECU_PLAIN;  sid = hi1; hit = 1'b1;
    end else if (lo1 == MAGIC_CIPHER) begin
      secu_o = SECU_CIPHER; sid = hi1; hit = 1'b1;
    end
    sect_o = SECT_NONE;
    if (hit && sid == SECT_ID_PERIPH)    sect_o = SECT_PERIPH;
    else if (hit && sid == SECT_ID_CORE) sect_o = SECT_CORE;
  end

  AST_SECT_NEEDS_MAGIC: assert property (@(posedge clk) disable iff (!rst_n)
    (secu_o == SECU_INVALID) |-> (sect_o == SECT_NONE)); // R7

endmodule

// File: rtl/cfg_hdr_inspector.sv
module cfg_hdr_inspector
  import cfg_hdr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter logic [DATA_W/2-1:0] MAGIC_PLAIN    = 16'hA5C3,
  parameter logic [DATA_W/2-1:0] MAGIC_CIPHER   = 16'h5A3C,
  parameter logic [DATA_W/2-1:0] SECT_ID_PERIPH = 16'h0F01,
  parameter logic [DATA_W/2-1:0] SECT_ID_CORE   = 16'h0F02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              width32_i,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              encrypted_o,
  output logic              compressed_o,
  output logic [1:0]        section_o,
  output logic [1:0]        security_o,
  output logic [1:0]        ratio_o,
  output logic              done_o,
  output logic              error_o
);

  localparam int CNT_W = $clog2(CMP_IDX + 1);

  logic             take, fin_ok, fin_err, wide_q;
  logic [CNT_W-1:0] idx;
  logic             enc_raw, cmp_raw;
  sect_e            sect_raw;
  secu_e            secu_raw;

  // Observer only: never stalls the stream
  assign s_ready = 1'b1;

  cfg_hdr_tracker #(.LAST_IDX(CMP_IDX), .CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .beat_i(s_valid && s_ready), .last_i(s_last),
    .take_o(take), .idx_o(idx), .fin_ok_o(fin_ok), .fin_err_o(fin_err)
  );

  cfg_hdr_image #(
    .DATA_W(DATA_W), .ENC_IDX(ENC_IDX), .CMP_IDX(CMP_IDX), .CNT_W(CNT_W),
    .MAGIC_PLAIN(MAGIC_PLAIN), .MAGIC_CIPHER(MAGIC_CIPHER),
    .SECT_ID_PERIPH(SECT_ID_PERIPH), .SECT_ID_CORE(SECT_ID_CORE)
  ) u_img (
    .clk(clk), .rst_n(rst_n), .take_i(take), .idx_i(idx), .data_i(s_data),
    .enc_o(enc_raw), .cmp_o(cmp_raw), .sect_o(sect_raw), .secu_o(secu_raw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || start_i) begin
      encrypted_o  <= 1'b0;
      compressed_o <= 1'b0;
      section_o    <= SECT_NONE;
      security_o   <= SECU_INVALID;
      ratio_o      <= RATIO_X1;
      done_o       <= 1'b0;
      error_o      <= 1'b0;
      wide_q       <= rst_n ? width32_i : 1'b0;
    end else if (fin_ok) begin
      encrypted_o  <= enc_raw;
      compressed_o <= cmp_raw;
      section_o    <= sect_raw;
      security_o   <= secu_raw;
      ratio_o      <= pick_ratio(enc_raw, cmp_raw, wide_q);
      done_o       <= 1'b1;
    end else if (fin_err) begin
      done_o  <= 1'b1;
      error_o <= 1'b1;
    end
  end

  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(ratio_o) && $stable(section_o)
      && $stable(security_o) && $stable(encrypted_o) && $stable(compressed_o)
      && $stable(error_o))); // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && !error_o && ratio_o == 2'd0)); // R10

  AST_ERROR_NO_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (done_o && ratio_o == 2'd0 && security_o == 2'd0)); // R9

  AST_PLAIN_IS_X1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !encrypted_o && !compressed_o) |-> (ratio_o == 2'd0)); // R4

  AST_COMPRESSED_AT_LEAST_X4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && compressed_o) |-> (ratio_o >= 2'd2)); // R5

endmodule

// File: tb/cfg_hdr_inspector_tb.sv
`timescale 1ns/1ps
module cfg_hdr_inspector_tb;

  localparam logic [15:0] MP = 16'hA5C3;
  localparam logic [15:0] MC = 16'h5A3C;
  localparam logic [15:0] SP = 16'h0F01;
  localparam logic [15:0] SC = 16'h0F02;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, width32_i = 1'b0, s_valid = 1'b0, s_last = 1'b0;
  logic [31:0] s_data = '0;
  logic s_ready, encrypted_o, compressed_o, done_o, error_o;
  logic [1:0] section_o, security_o, ratio_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfg_hdr_inspector u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .width32_i(width32_i),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .encrypted_o(encrypted_o), .compressed_o(compressed_o),
    .section_o(section_o), .security_o(security_o), .ratio_o(ratio_o),
    .done_o(done_o), .error_o(error_o)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // p: 0 w0 plain, 1 w0 cipher, 2 w1 plain, 3 w1 cipher, 4 no magic
  // k: 0 peripheral id, 1 core id, 2 foreign id; e: bits[3:2] of word 69
  // c: bit 1 of word 229
  function automatic logic [31:0] mk_word(int idx, int p, int k, int e, int c);
    logic [15:0] sid, mg;
    logic [31:0] w;
    sid = (k == 0) ? SP : (k == 1) ? SC : 16'h7777;
    mg  = (p == 0 || p == 2) ? MP : MC;
    w   = {16'hBEEF - 16'(idx), 16'(idx * 3)};
    if (idx == 0)
      w = (p < 2) ? {sid, mg} : (p < 4) ? 32'h1111_0000 : 32'h2222_3333;
    else if (idx == 1)
      w = (p < 2) ? 32'h4444_0001 : (p < 4) ? {sid, mg} : {sid, 16'h6666};
    else if (idx == 69)
      w[3:2] = 2'(e);
    else if (idx == 229)
      w[1] = 1'(c);
    return w;
  endfunction

  task automatic pulse_start(input logic w32);
    @(negedge clk);
    start_i = 1'b1; width32_i = w32; s_valid = 1'b0; s_last = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send(input logic [31:0] d, input logic lst);
    s_valid = 1'b1; s_data = d; s_last = lst;
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic feed(int p, int k, int e, int c, int n, bit lst, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 9) == 4) @(negedge clk);
      send(mk_word(i, p, k, e, c), lst && (i == n - 1));
    end
  endtask

  task automatic expect_ok(int p, int k, int e, int c, int w);
    int mult;
    mult = 1;
    if (c == 0) mult = w ? 8 : 4;
    else if (e != 0) mult = w ? 4 : 2;
    check("R8 done", done_o, 1);
    check("R8/R9 no error", error_o, 0);
    check("R2 encrypted", encrypted_o, (e != 0));
    check("R3 compressed", compressed_o, (c == 0));
    if (w) check("R5 ratio 32-bit", ratio_o, $clog2(mult));
    else   check("R4 ratio 16-bit", ratio_o, $clog2(mult));
    check("R6 security", security_o,
          (p == 4) ? 0 : (p == 0 || p == 2) ? 1 : 2);
    check("R7 section", section_o, (p == 4 || k == 2) ? 0 : k + 1);
  endtask

  task automatic expect_err();
    check("R9 done", done_o, 1);
    check("R9 error", error_o, 1);
    check("R9 ratio", ratio_o, 0);
    check("R9 fields", {encrypted_o, compressed_o, section_o, security_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset done", done_o, 0);
    check("R10 reset error", error_o, 0);
    check("R10 reset ratio", ratio_o, 0);
    check("R1 ready", s_ready, 1);

    // R1: beats before any start have no effect
    for (int i = 0; i < 5; i++) send(mk_word(i, 0, 0, 1, 0), i == 4);
    @(negedge clk);
    check("R1 ignored before start", {done_o, error_o}, 0);

    // Full sweep over image variants, flags and width
    for (int p = 0; p < 5; p++)
      for (int k = 0; k < 3; k++)
        for (int e = 0; e < 4; e++)
          for (int c = 0; c < 2; c++)
            for (int w = 0; w < 2; w++) begin
              pulse_start(1'(w));
              width32_i = ~1'(w);
              feed(p, k, e, c, 230, (w == 0), ((p + k + e) % 2) == 1);
              check("R8 not early", done_o, 0);
              @(negedge clk);
              expect_ok(p, k, e, c, w);
              if (p == 0 && k == 0) begin
                // R1: extra beats after completion change nothing
                send(32'h0000_0000, 1'b0);
                send(32'hFFFF_FFFF, 1'b1);
                @(negedge clk);
                expect_ok(p, k, e, c, w);
              end
            end

    // R9: early endings, including the last short index 228
    for (int t = 0; t < 3; t++) begin
      pulse_start(1'(t % 2));
      feed(1, 1, 3, 0, (t == 0) ? 1 : (t == 1) ? 70 : 229, 1'b1, 1'b0);
      check("R9 not early", done_o, 0);
      @(negedge clk);
      expect_err();
    end

    // R10: start during a run aborts it
    pulse_start(1'b1);
    feed(4, 2, 0, 1, 100, 1'b0, 1'b0);
    pulse_start(1'b0);
    feed(2, 0, 2, 1, 230, 1'b0, 1'b0);
    @(negedge clk);
    expect_ok(2, 0, 2, 1, 0);

    // R10: start in the cycle a completion is due, junk beat alongside
    pulse_start(1'b1);
    feed(3, 1, 0, 0, 230, 1'b0, 1'b0);
    start_i = 1'b1; width32_i = 1'b0; s_valid = 1'b1; s_data = 32'h0;
    @(negedge clk);
    start_i = 1'b0; s_valid = 1'b0; width32_i = 1'b1;
    check("R10 start beats completion", {done_o, error_o}, 0);
    feed(0, 1, 1, 1, 230, 1'b1, 1'b0);
    @(negedge clk);
    expect_ok(0, 1, 1, 1, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule